// File: doc/BRIEF.md
# Two-Tier Nested Interrupt Controller

This block decides, at each instruction boundary of a small 8-bit processor core, whether the core should enter an interrupt routine and which one. There are six sources. One line cannot be masked and is edge-triggered. One standard maskable line and four secondary maskable lines are level-sensitive. The non-maskable line and the standard line form the high tier. The four secondary lines form the low tier. A high-tier request may interrupt a running low-tier routine. Low-tier routines never interrupt one another.

The controller records which routine levels are currently open as a nesting stack with a fixed order. The secondary level sits at the bottom, the standard level above it, and the non-maskable level on top. Each return strobe from the core closes the most recently opened level. When a request is accepted, the controller gives a one-cycle take pulse together with a 3-bit vector code. The core uses these to save its few 8-bit registers and jump. Register stacking and the vector table are outside this block.

The nesting is kept in one enumerated state register with eight states. Each state names the set of open levels:

| State | Open levels |
|---|---|
| ST_IDLE | none |
| ST_LO | secondary |
| ST_HI | standard |
| ST_LO_HI | secondary and standard |
| ST_NMI | non-maskable |
| ST_LO_NMI | secondary and non-maskable |
| ST_HI_NMI | standard and non-maskable |
| ST_ALL | all three |

An accepted request pushes a level, which is a transition to the state that includes it:

| Accepted request | Transitions |
|---|---|
| Secondary | ST_IDLE to ST_LO |
| Standard | ST_IDLE to ST_HI, ST_LO to ST_LO_HI |
| Non-maskable | ST_IDLE to ST_NMI, ST_LO to ST_LO_NMI, ST_HI to ST_HI_NMI, ST_LO_HI to ST_ALL |

A return strobe pops the highest open level, which reverses the transitions above. A return strobe in ST_IDLE leaves the state at ST_IDLE.

Top module: `tier_irq_ctrl`

## Requirements
- R1: After reset `take_int` is 0, `take_vec` is 0 and no routine level is open.
- R2: When several sources are eligible at one boundary, the winner follows the fixed priority non-maskable, standard, secondary 0, secondary 1, secondary 2, secondary 3. Their vector codes are 0, 1, 2, 3, 4 and 5.
- R3: A request is accepted only in a cycle with `insn_boundary` high. Without the strobe, `take_int` stays 0 whatever the request lines do.
- R4: A rising edge on `nmi_line` is latched as pending. The pending request is kept until it is accepted, even after the line falls or while a non-maskable routine is open. A line held high gives only one request. Neither `int_disable` nor the enable bits affect it.
- R5: The standard line is eligible only with `src_enable[0]`=1. Secondary line k is eligible only with `src_enable[k+1]`=1. All five maskable lines are blocked while `int_disable`=1.
- R6: While a secondary routine is open, no secondary request is accepted.
- R7: The standard and non-maskable requests are accepted while a secondary routine is open. This preempts it.
- R8: A standard request is not accepted while a standard or non-maskable routine is open. A non-maskable request is not accepted while a non-maskable routine is open.
- R9: `rti_strobe` closes the highest open level in the order non-maskable, then standard, then secondary. The low tier becomes free again only when the secondary level closes. A return with no open level has no effect.
- R10: When `rti_strobe` and `insn_boundary` are high in the same cycle, the return is processed and no request is accepted in that cycle.
- R11: An acceptance at the boundary in cycle n gives `take_int`=1 for cycle n+1 only. During that cycle `take_vec` shows the code, and `take_vec` keeps that value until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_line | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_line | input | 1 | Standard maskable request, level |
| sec_line | input | 4 | Secondary maskable requests, level, bit k = secondary k |
| src_enable | input | 5 | Bit 0 enables the standard line, bit k+1 enables secondary k |
| int_disable | input | 1 | Global block of all maskable lines |
| insn_boundary | input | 1 | High in the cycle before the next instruction fetch |
| rti_strobe | input | 1 | High when the core executes a return from interrupt |
| take_int | output | 1 | One-cycle pulse: enter a routine |
| take_vec | output | 3 | Vector code of the accepted source |

## Verification
The first pattern raises several lines together, which tests the fixed priority order. The second raises lines while routines are open at each nesting depth. This separates low-tier blocking from high-tier preemption and non-maskable re-entry. The third applies short and held non-maskable pulses, and combines the disable input with each enable bit. This shows that edge latching is independent of masking. Long random runs, which include returns on boundary cycles and returns with nothing open, are compared against a flag-based model on every clock. These runs reach stack orderings that the directed sequences do not.

// File: rtl/tier_irq_pkg.sv
package tier_irq_pkg;

    localparam int NUM_SEC  = 4;
    localparam int NUM_SRC  = 2 + NUM_SEC;
    localparam int VEC_W    = $clog2(NUM_SRC);

    localparam int CODE_NMI  = 0;
    localparam int CODE_IRQ  = 1;
    localparam int CODE_SEC0 = 2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LO     = 3'd1,
        ST_HI     = 3'd2,
        ST_LO_HI  = 3'd3,
        ST_NMI    = 3'd4,
        ST_LO_NMI = 3'd5,
        ST_HI_NMI = 3'd6,
        ST_ALL    = 3'd7
    } nest_state_e;

endpackage

// File: rtl/tic_edge_latch.sv
module tic_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic consume,
    output logic pending
);

    logic line_q;
    logic rise;

    assign rise = line_in & ~line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            line_q  <= line_in;
            pending <= rise | (pending & ~consume);
        end
    end

endmodule

// File: rtl/tic_qualify.sv
module tic_qualify #(
    parameter int NUM_SEC = 4,
    localparam int NUM_SRC = 2 + NUM_SEC
) (
    input  logic               nmi_pend,
    input  logic               irq_line,
    input  logic [NUM_SEC-1:0] sec_line,
    input  logic [NUM_SEC:0]   src_enable,
    input  logic               int_disable,
    input  logic               busy_lo,
    input  logic               busy_irq,
    input  logic               busy_nmi,
    output logic [NUM_SRC-1:0] eligible
);

    logic high_free;
    logic low_free;

    assign high_free = ~busy_irq & ~busy_nmi;
    assign low_free  = high_free & ~busy_lo;

    assign eligible[0] = nmi_pend & ~busy_nmi;
    assign eligible[1] = irq_line & src_enable[0] & ~int_disable & high_free;

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
        assign eligible[2+k] = sec_line[k] & src_enable[k+1] & ~int_disable & low_free;
    end

endmodule

// File: rtl/tic_pick.sv
module tic_pick #(
    parameter int N = 6,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] code
);

    always_comb begin
        hit  = |req;
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                code = W'(i);
            end
        end
    end

endmodule

// File: rtl/tier_irq_ctrl.sv
module tier_irq_ctrl
    import tier_irq_pkg::*;
#(
    parameter int SEC_LINES = NUM_SEC,
    localparam int SRC_N = 2 + SEC_LINES,
    localparam int VW    = $clog2(SRC_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_line,
    input  logic                 irq_line,
    input  logic [SEC_LINES-1:0] sec_line,
    input  logic [SEC_LINES:0]   src_enable,
    input  logic                 int_disable,
    input  logic                 insn_boundary,
    input  logic                 rti_strobe,
    output logic                 take_int,
    output logic [VW-1:0]        take_vec
);

    nest_state_e state, state_nx;

    logic             busy_lo, busy_irq, busy_nmi;
    logic             nmi_pend;
    logic [SRC_N-1:0] eligible;
    logic             win_hit;
    logic [VW-1:0]    win_code;
    logic             accept;
    logic             push_nmi, push_irq, push_lo;

    always_comb begin
        busy_lo  = 1'b0;
        busy_irq = 1'b0;
        busy_nmi = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_LO:     busy_lo = 1'b1;
            ST_HI:     busy_irq = 1'b1;
            ST_LO_HI:  begin busy_lo = 1'b1; busy_irq = 1'b1; end
            ST_NMI:    busy_nmi = 1'b1;
            ST_LO_NMI: begin busy_lo = 1'b1; busy_nmi = 1'b1; end
            ST_HI_NMI: begin busy_irq = 1'b1; busy_nmi = 1'b1; end
            ST_ALL:    begin busy_lo = 1'b1; busy_irq = 1'b1; busy_nmi = 1'b1; end
        endcase
    end

    tic_edge_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (nmi_line),
        .consume (push_nmi),
        .pending (nmi_pend)
    );

    tic_qualify #(.NUM_SEC(SEC_LINES)) u_qual (
        .nmi_pend    (nmi_pend),
        .irq_line    (irq_line),
        .sec_line    (sec_line),
        .src_enable  (src_enable),
        .int_disable (int_disable),
        .busy_lo     (busy_lo),
        .busy_irq    (busy_irq),
        .busy_nmi    (busy_nmi),
        .eligible    (eligible)
    );

    tic_pick #(.N(SRC_N)) u_pick (
        .req  (eligible),
        .hit  (win_hit),
        .code (win_code)
    );

    assign accept   = insn_boundary & ~rti_strobe & win_hit;
    assign push_nmi = accept & (win_code == VW'(CODE_NMI));
    assign push_irq = accept & (win_code == VW'(CODE_IRQ));
    assign push_lo  = accept & (win_code >= VW'(CODE_SEC0));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (push_nmi)      state_nx = ST_NMI;
                else if (push_irq) state_nx = ST_HI;
                else if (push_lo)  state_nx = ST_LO;
            end
            ST_LO: begin
                if (rti_strobe)    state_nx = ST_IDLE;
                else if (push_nmi) state_nx = ST_LO_NMI;
                else if (push_irq) state_nx = ST_LO_HI;
            end
            ST_HI: begin
                if (rti_strobe)    state_nx = ST_IDLE;
                else if (push_nmi) state_nx = ST_HI_NMI;
            end
            ST_LO_HI: begin
                if (rti_strobe)    state_nx = ST_LO;
                else if (push_nmi) state_nx = ST_ALL;
            end
            ST_NMI: begin
                if (rti_strobe)    state_nx = ST_IDLE;
            end
            ST_LO_NMI: begin
                if (rti_strobe)    state_nx = ST_LO;
            end
            ST_HI_NMI: begin
                if (rti_strobe)    state_nx = ST_HI;
            end
            ST_ALL: begin
                if (rti_strobe)    state_nx = ST_LO_HI;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_int <= 1'b0;
            take_vec <= '0;
        end else begin
            take_int <= accept;
            if (accept) take_vec <= win_code;
        end
    end

endmodule

// File: rtl/tier_irq_chk.sv
module tier_irq_chk #(
    parameter int VW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          take_int,
    input logic [VW-1:0] take_vec,
    input logic          insn_boundary,
    input logic          rti_strobe,
    input logic          int_disable,
    input logic          busy_lo,
    input logic          busy_nmi
);

    a_r3_take_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> $past(insn_boundary));

    a_r10_no_take_after_rti: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> !$past(rti_strobe));

    a_r11_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> (take_vec <= VW'(5)));

    a_r11_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        !take_int |-> $stable(take_vec));

    a_r6_no_low_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && take_vec >= VW'(2)) |-> !$past(busy_lo));

    a_r8_no_nmi_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && take_vec == VW'(0)) |-> !$past(busy_nmi));

    a_r5_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && take_vec != VW'(0)) |-> !$past(int_disable));

endmodule

bind tier_irq_ctrl tier_irq_chk #(.VW(VW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_int      (take_int),
    .take_vec      (take_vec),
    .insn_boundary (insn_boundary),
    .rti_strobe    (rti_strobe),
    .int_disable   (int_disable),
    .busy_lo       (busy_lo),
    .busy_nmi      (busy_nmi)
);

// File: tb/sim_tier_irq_ctrl.sv
`timescale 1ns/1ps
module sim_tier_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_line = 1'b0;
    logic       irq_line = 1'b0;
    logic [3:0] sec_line = 4'h0;
    logic [4:0] src_enable = 5'h1F;
    logic       int_disable = 1'b0;
    logic       insn_boundary = 1'b0;
    logic       rti_strobe = 1'b0;
    logic       take_int;
    logic [2:0] take_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tier_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .irq_line(irq_line),
        .sec_line(sec_line), .src_enable(src_enable), .int_disable(int_disable),
        .insn_boundary(insn_boundary), .rti_strobe(rti_strobe),
        .take_int(take_int), .take_vec(take_vec)
    );

    // behavioural reference: three open-level flags and a pending bit
    bit m_prev, m_pend, m_lo, m_hi, m_nmi;
    bit exp_take;
    int exp_vec;

    always @(posedge clk) begin
        int won;
        bit rise;
        if (!rst_n) begin
            m_prev = 0; m_pend = 0; m_lo = 0; m_hi = 0; m_nmi = 0;
            exp_take = 0; exp_vec = 0;
        end else begin
            won = -1;
            rise = nmi_line && !m_prev;
            if (rti_strobe) begin
                if (m_nmi) m_nmi = 0;
                else if (m_hi) m_hi = 0;
                else if (m_lo) m_lo = 0;
            end else if (insn_boundary) begin
                if (m_pend && !m_nmi) won = 0;
                else if (irq_line && src_enable[0] && !int_disable && !m_hi && !m_nmi) won = 1;
                else if (!m_lo && !m_hi && !m_nmi && !int_disable) begin
                    for (int k = 3; k >= 0; k--)
                        if (sec_line[k] && src_enable[k+1]) won = 2 + k;
                end
            end
            m_pend = rise || (m_pend && won != 0);
            m_prev = nmi_line;
            if (won == 0) m_nmi = 1;
            else if (won == 1) m_hi = 1;
            else if (won >= 2) m_lo = 1;
            exp_take = (won >= 0);
            if (won >= 0) exp_vec = won;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (take_int !== exp_take || take_vec !== exp_vec[2:0]) begin
                errors++;
                $display("FAIL R11 model compare: take=%0d vec=%0d expected take=%0d vec=%0d",
                         take_int, take_vec, exp_take, exp_vec);
            end
        end
    end

    task automatic tick(input logic b, input logic r);
        insn_boundary = b;
        rti_strobe = r;
        @(posedge clk);
        #1;
        insn_boundary = 1'b0;
        rti_strobe = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic et, input int ev);
        checks++;
        if (take_int !== et || (et && take_vec !== ev[2:0])) begin
            errors++;
            $display("FAIL %s: take=%0d vec=%0d expected take=%0d vec=%0d",
                     tag, take_int, take_vec, et, ev);
        end
    endtask

    task automatic nmi_pulse();
        nmi_line = 1'b1;
        tick(0, 0);
        nmi_line = 1'b0;
        tick(0, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(0, 0);
        expect_out("R1 reset state", 0, 0);
        checks++;
        if (take_vec !== 3'd0) begin
            errors++;
            $display("FAIL R1 reset vec: vec=%0d expected 0", take_vec);
        end

        // R3: no boundary, no take
        irq_line = 1;
        tick(0, 0); expect_out("R3 no boundary", 0, 0);
        tick(0, 0); expect_out("R3 no boundary", 0, 0);
        tick(1, 0); expect_out("R2 standard alone", 1, 1);
        tick(1, 0); expect_out("R8 standard re-entry blocked", 0, 0);
        expect_out("R11 vec held", 0, 0);
        checks++;
        if (take_vec !== 3'd1) begin
            errors++;
            $display("FAIL R11 vec hold: vec=%0d expected 1", take_vec);
        end
        tick(0, 1); irq_line = 0;

        // R2 priority
        irq_line = 1; sec_line = 4'b1010;
        tick(1, 0); expect_out("R2 standard over secondary", 1, 1);
        tick(0, 1); irq_line = 0;
        tick(1, 0); expect_out("R2 secondary1 over secondary3", 1, 3);

        // R6: low tier busy
        tick(1, 0); expect_out("R6 secondary blocked", 0, 0);
        sec_line = 4'b0001;
        tick(1, 0); expect_out("R6 higher secondary blocked", 0, 0);

        // R7: preemption
        irq_line = 1;
        tick(1, 0); expect_out("R7 standard preempts", 1, 1);
        nmi_pulse();
        tick(1, 0); expect_out("R7 R4 latched non-maskable preempts", 1, 0);

        // R8 / R10 / R4
        nmi_pulse();
        tick(1, 0); expect_out("R8 no non-maskable re-entry", 0, 0);
        tick(1, 1); expect_out("R10 return with boundary", 0, 0);
        tick(1, 0); expect_out("R4 pending kept while active", 1, 0);
        tick(0, 1);
        tick(0, 1); irq_line = 0;
        tick(1, 0); expect_out("R9 low tier still busy", 0, 0);
        tick(0, 1);
        tick(1, 0); expect_out("R9 low tier freed", 1, 2);
        tick(0, 1);

        // R5 masking
        src_enable = 5'b11101;
        tick(1, 0); expect_out("R5 secondary0 enable off", 0, 0);
        src_enable = 5'h1F; int_disable = 1; irq_line = 1;
        tick(1, 0); expect_out("R5 global disable", 0, 0);
        nmi_pulse();
        tick(1, 0); expect_out("R4 unmaskable", 1, 0);
        tick(0, 1);
        int_disable = 0; src_enable = 5'b11110; sec_line = 4'h0;
        tick(1, 0); expect_out("R5 standard enable off", 0, 0);
        src_enable = 5'h1F; irq_line = 0;

        // R4 held level
        nmi_line = 1; tick(0, 0);
        tick(1, 0); expect_out("R4 edge taken", 1, 0);
        tick(0, 1);
        tick(1, 0); expect_out("R4 held level single request", 0, 0);
        nmi_line = 0; tick(0, 0);

        // R9 empty return, R2 lowest code
        tick(0, 1);
        sec_line = 4'b1000;
        tick(1, 0); expect_out("R9 R2 empty return then secondary3", 1, 5);
        tick(0, 1); sec_line = 4'h0;

        // random phase, compared with the model every clock
        for (int i = 0; i < 4000; i++) begin
            nmi_line   = ($urandom % 7) == 0;
            irq_line   = ($urandom % 3) == 0;
            sec_line   = 4'($urandom);
            src_enable = 5'($urandom) | 5'b10101;
            int_disable = ($urandom % 5) == 0;
            tick(($urandom % 2) == 0, ($urandom % 5) == 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule